// File: doc/BRIEF.md
# Rational Stream Decimator

This block thins a framed pixel stream by dropping items. It does no interpolation. Three rational factors N/M, each with N no greater than M, apply separately: one to the columns of a line, one to the lines of a frame, and one to whole frames. Each axis keeps its own accumulator, and that accumulator decides for every column, line or frame whether it is kept or dropped.

The input is a valid-qualified stream. A start-of-frame flag marks the first pixel of a frame, and an end-of-line flag marks the last pixel of each line. The output is the same stream with the dropped items removed, delayed by one clock. Each accumulator is preset so that the first item on its axis is always kept. The end-of-line pixel of a kept line is always emitted, so every kept line closes with its marker.

Top module: `rate_decimator`

## Requirements
- R1: While reset is held, and after it until a selected item arrives, out_valid_o is low.
- R2: A selected input item appears on the outputs exactly one clock later, with the same data, start-of-frame flag and end-of-line flag.
- R3: Within a line, column index i (counted from 0) is kept if i is 0 or if floor(i*N/M) > floor((i-1)*N/M), using the horizontal factor pair.
- R4: Within a frame, line index j is kept by the same rule using the vertical factor pair. A dropped line produces no output at all, including no end-of-line marker.
- R5: Frame index k, counted from the first start-of-frame after enable_i rises, is kept by the same rule using the 6-bit frame factor pair. A dropped frame produces no output.
- R6: On any axis where N is 0, M is 0 or N >= M, every item on that axis passes.
- R7: In a kept line of a kept frame, the item carrying the end-of-line flag is always emitted with that flag, even when the column rule would drop it. The first item of a kept frame is emitted with the start-of-frame flag.
- R8: The horizontal and vertical factors are sampled on the start-of-frame item. Changing them during a frame has no effect until the next frame.
- R9: While enable_i is low, nothing is emitted and the frame count restarts. Items that arrive after enable before the first start-of-frame are dropped.
- R10: Cycles with in_valid_i low do not advance any accumulator and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Capture enable; low discards the stream and restarts frame counting |
| h_num_i | input | SPAN_W | Horizontal numerator N |
| h_den_i | input | SPAN_W | Horizontal denominator M |
| v_num_i | input | SPAN_W | Vertical numerator N |
| v_den_i | input | SPAN_W | Vertical denominator M |
| f_num_i | input | RATE_W | Frame-rate numerator N |
| f_den_i | input | RATE_W | Frame-rate denominator M |
| in_valid_i | input | 1 | Input item valid |
| in_data_i | input | DATA_W | Input pixel |
| in_sof_i | input | 1 | Input item is the first pixel of a frame |
| in_eol_i | input | 1 | Input item is the last pixel of a line |
| out_valid_o | output | 1 | Output item valid |
| out_data_o | output | DATA_W | Output pixel |
| out_sof_o | output | 1 | Output item starts a frame |
| out_eol_o | output | 1 | Output item ends a line |

## Verification
The bench targets five failure modes:
- Lines whose width is not a multiple of the horizontal ratio. If the forced end-of-line item is not emitted, kept lines arrive one pixel short and without their closing marker.
- Factors of zero and numerators larger than the denominator. A design that does not bypass these stalls, or drops items under an ill-formed ratio.
- Horizontal factors changed in the middle of a frame. A design that does not latch them at frame start narrows the remaining lines of that frame.
- Long frame-rate sequences across enable toggles. A frame accumulator that is not restarted drops the first frame after re-enable.
- Idle cycles inside lines. A design that advances its accumulators on idle cycles keeps the wrong columns.

// File: rtl/rd_pkg.sv
package rd_pkg;
  localparam int SPAN_W_DEF = 16;
  localparam int RATE_W_DEF = 6;
  localparam int DATA_W_DEF = 16;
endpackage

// File: rtl/rd_step.sv
// One accumulator step of N/M drop selection; restart presets to M-N so item 0 is kept.
module rd_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] acc_i,
  input  logic         restart_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         keep_o,
  output logic [W-1:0] acc_o
);
  logic         bypass;
  logic [W-1:0] base;
  logic [W:0]   sum;
  logic [W:0]   rem;

  assign bypass = (num_i == '0) || (den_i == '0) || (num_i >= den_i);
  assign base   = restart_i ? (den_i - num_i) : acc_i;
  assign sum    = {1'b0, base} + {1'b0, num_i};
  assign rem    = sum - {1'b0, den_i};

  always_comb begin
    if (bypass) begin
      keep_o = 1'b1;
      acc_o  = '0;
    end else if (sum >= {1'b0, den_i}) begin
      keep_o = 1'b1;
      acc_o  = rem[W-1:0];
    end else begin
      keep_o = 1'b0;
      acc_o  = sum[W-1:0];
    end
  end
endmodule

// File: rtl/rd_out_stage.sv
module rd_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sof_i,
  input  logic              eol_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sof_o,
  output logic              eol_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      sof_o   <= 1'b0;
      eol_o   <= 1'b0;
    end else begin
      valid_o <= sel_i;
      data_o  <= sel_i ? data_i : data_o;
      sof_o   <= sel_i & sof_i;
      eol_o   <= sel_i & eol_i;
    end
  end
endmodule

// File: rtl/rate_decimator.sv
module rate_decimator
  import rd_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int SPAN_W = SPAN_W_DEF,
  parameter int RATE_W = RATE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [SPAN_W-1:0] h_num_i,
  input  logic [SPAN_W-1:0] h_den_i,
  input  logic [SPAN_W-1:0] v_num_i,
  input  logic [SPAN_W-1:0] v_den_i,
  input  logic [RATE_W-1:0] f_num_i,
  input  logic [RATE_W-1:0] f_den_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eol_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eol_o
);
  logic              in_frame_q, f_fresh_q, frame_keep_q, line_keep_q, line_start_q;
  logic [RATE_W-1:0] f_acc_q, f_acc_d;
  logic [SPAN_W-1:0] v_acc_q, v_acc_d, h_acc_q, h_acc_d;
  logic [SPAN_W-1:0] h_num_q, h_den_q, v_num_q, v_den_q;
  logic [SPAN_W-1:0] h_num_e, h_den_e, v_num_e, v_den_e;
  logic              f_keep, v_keep, h_keep;
  logic              line_first, in_frame_now, frame_keep_now, line_keep_now, sel;

  // factors in force for this item: live on the frame-start item, latched otherwise
  assign h_num_e = in_sof_i ? h_num_i : h_num_q;
  assign h_den_e = in_sof_i ? h_den_i : h_den_q;
  assign v_num_e = in_sof_i ? v_num_i : v_num_q;
  assign v_den_e = in_sof_i ? v_den_i : v_den_q;

  assign line_first = in_sof_i | line_start_q;

  rd_step #(.W(RATE_W)) u_frame_step (
    .acc_i(f_acc_q), .restart_i(f_fresh_q), .num_i(f_num_i), .den_i(f_den_i),
    .keep_o(f_keep), .acc_o(f_acc_d)
  );
  rd_step #(.W(SPAN_W)) u_line_step (
    .acc_i(v_acc_q), .restart_i(in_sof_i), .num_i(v_num_e), .den_i(v_den_e),
    .keep_o(v_keep), .acc_o(v_acc_d)
  );
  rd_step #(.W(SPAN_W)) u_col_step (
    .acc_i(h_acc_q), .restart_i(line_first), .num_i(h_num_e), .den_i(h_den_e),
    .keep_o(h_keep), .acc_o(h_acc_d)
  );

  assign in_frame_now   = in_sof_i | in_frame_q;
  assign frame_keep_now = in_sof_i ? f_keep : frame_keep_q;
  assign line_keep_now  = line_first ? v_keep : line_keep_q;
  assign sel = in_valid_i & enable_i & in_frame_now & frame_keep_now & line_keep_now
             & (h_keep | in_eol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q   <= 1'b0;
      f_fresh_q    <= 1'b1;
      frame_keep_q <= 1'b0;
      line_keep_q  <= 1'b0;
      line_start_q <= 1'b0;
      f_acc_q      <= '0;
      v_acc_q      <= '0;
      h_acc_q      <= '0;
      h_num_q      <= '0;
      h_den_q      <= '0;
      v_num_q      <= '0;
      v_den_q      <= '0;
    end else if (!enable_i) begin
      in_frame_q   <= 1'b0;
      f_fresh_q    <= 1'b1;
      line_start_q <= 1'b0;
    end else if (in_valid_i) begin
      if (in_sof_i) begin
        in_frame_q   <= 1'b1;
        f_fresh_q    <= 1'b0;
        f_acc_q      <= f_acc_d;
        frame_keep_q <= f_keep;
        h_num_q      <= h_num_i;
        h_den_q      <= h_den_i;
        v_num_q      <= v_num_i;
        v_den_q      <= v_den_i;
      end
      if (in_frame_now) begin
        line_start_q <= in_eol_i;
        h_acc_q      <= h_acc_d;
        if (line_first) begin
          v_acc_q     <= v_acc_d;
          line_keep_q <= v_keep;
        end
      end
    end
  end

  rd_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .data_i(in_data_i),
    .sof_i(in_sof_i), .eol_i(in_eol_i), .valid_o(out_valid_o),
    .data_o(out_data_o), .sof_o(out_sof_o), .eol_o(out_eol_o)
  );
endmodule

// File: rtl/rd_checker.sv
module rd_checker #(
  parameter int DATA_W = 16,
  parameter int RATE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic [RATE_W-1:0] f_num_i,
  input logic [RATE_W-1:0] f_den_i,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              in_sof_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_sof_o,
  input logic              out_eol_o
);
  AST_SOF_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sof_o |-> out_valid_o); // R2
  AST_EOL_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eol_o |-> out_valid_o); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !out_valid_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R10
  AST_DATA_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && enable_i) |=> (!out_valid_o || out_data_o == $past(in_data_i))); // R2
  AST_FRAME_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && enable_i && in_sof_i && f_num_i == f_den_i) |=> (out_valid_o && out_sof_o)); // R6
endmodule

bind rate_decimator rd_checker #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_rd_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .f_num_i(f_num_i),
  .f_den_i(f_den_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
  .in_sof_i(in_sof_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
  .out_sof_o(out_sof_o), .out_eol_o(out_eol_o)
);

// File: tb/rate_decimator_test.sv
`timescale 1ns/1ps
module rate_decimator_test;
  localparam int DW = 16;
  localparam int NV = 8;
  localparam int CAP = 4096;
  // hn hm vn vm fn fm w h frames gaps
  localparam int TBL [0:NV-1][0:9] = '{
    '{1, 1, 1, 1, 0,  0,  6, 3, 1, 0},
    '{1, 2, 1, 1, 1,  1,  8, 2, 1, 0},
    '{2, 3, 1, 2, 0,  0,  9, 4, 1, 1},
    '{1, 3, 2, 5, 1,  1, 10, 5, 1, 0},
    '{0, 7, 7, 7, 3,  3,  5, 3, 1, 1},
    '{5, 3, 1, 4, 0,  1,  4, 6, 1, 0},
    '{1, 1, 1, 1, 1,  3,  3, 2, 4, 0},
    '{3, 4, 2, 3, 40, 63, 7, 4, 3, 1}
  };
  localparam string TAG [0:NV-1] = '{"R6", "R7", "R10", "R4", "R6", "R6", "R5", "R3"};

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [15:0] hn = '0, hm = '0, vn = '0, vm = '0;
  logic [5:0]  fn = '0, fm = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_sof, out_eol;
  logic [DW-1:0] out_data;

  int checks = 0, fails = 0;
  int cap_n = 0, exp_n = 0;
  logic [DW+1:0] cap [CAP];
  logic [DW+1:0] expv [CAP];

  always #2.5 clk = ~clk;

  rate_decimator uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .h_num_i(hn), .h_den_i(hm),
    .v_num_i(vn), .v_den_i(vm), .f_num_i(fn), .f_den_i(fm), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_sof_i(in_sof), .in_eol_i(in_eol), .out_valid_o(out_valid),
    .out_data_o(out_data), .out_sof_o(out_sof), .out_eol_o(out_eol)
  );

  always @(negedge clk) if (out_valid && cap_n < CAP) begin
    cap[cap_n] = {out_sof, out_eol, out_data};
    cap_n++;
  end

  function automatic bit pick(int i, int n, int m);
    if (n == 0 || m == 0 || n >= m || i == 0) return 1'b1;
    return (i * n) / m > ((i - 1) * n) / m;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_cap();
    cap_n = 0;
    exp_n = 0;
  endtask

  task automatic compare(string req);
    int bad = -1;
    repeat (3) @(negedge clk);
    check(cap_n == exp_n, req, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      if (bad < 0 && cap[i] !== expv[i]) bad = i;
    check(bad < 0, req, (bad < 0) ? 0 : int'(cap[bad]), (bad < 0) ? 0 : int'(expv[bad]));
  endtask

  // drives one frame at negedges; builds expected items for frame index fi
  task automatic send_frame(int a_hn, int a_hm, int a_vn, int a_vm, int a_fn, int a_fm,
                            int w, int h, int fi, bit gaps, bit midchg);
    bit fk = pick(fi, a_fn, a_fm);
    hn = 16'(a_hn); hm = 16'(a_hm); vn = 16'(a_vn); vm = 16'(a_vm);
    fn = 6'(a_fn); fm = 6'(a_fm);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        if (gaps && ((r + c) % 3 == 1)) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
        if (midchg && r == 1 && c == 0) begin
          hn = 16'd1; hm = 16'd1;
        end
        in_valid = 1'b1;
        in_data  = {8'(r), 8'(c)};
        in_sof   = (r == 0 && c == 0);
        in_eol   = (c == w - 1);
        if (fk && pick(r, a_vn, a_vm) && (pick(c, a_hn, a_hm) || c == w - 1)) begin
          expv[exp_n] = {(r == 0 && c == 0), (c == w - 1), 8'(r), 8'(c)};
          exp_n++;
        end
        @(negedge clk);
      end
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1", out_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0 && cap_n == 0, "R1", cap_n, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      en = 1'b0;
      repeat (2) @(negedge clk);
      en = 1'b1;
      for (int f = 0; f < TBL[v][8]; f++) begin
        clear_cap();
        send_frame(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3], TBL[v][4], TBL[v][5],
                   TBL[v][6], TBL[v][7], f, TBL[v][9] != 0, 1'b0);
        compare(TAG[v]);
      end
    end

    // R9: disabled input ignored
    en = 1'b0;
    clear_cap();
    send_frame(1, 1, 1, 1, 0, 0, 4, 2, 0, 1'b0, 1'b0);
    exp_n = 0;
    compare("R9");

    // R9: items before the first start-of-frame after enable are dropped
    en = 1'b1;
    clear_cap();
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1; in_sof = 1'b0; in_eol = (i == 4); in_data = 16'hEE00 + 16'(i);
      @(negedge clk);
    end
    in_valid = 1'b0; in_eol = 1'b0;
    send_frame(1, 2, 1, 1, 0, 0, 6, 2, 0, 1'b0, 1'b0);
    compare("R9");

    // R8: factor change mid-frame has no effect
    en = 1'b0; @(negedge clk); en = 1'b1;
    clear_cap();
    send_frame(1, 3, 1, 1, 0, 0, 9, 3, 0, 1'b0, 1'b1);
    compare("R8");

    // R2 + R7: odd width at 1/2, single-cycle latency on forced end-of-line item
    en = 1'b0; @(negedge clk); en = 1'b1;
    clear_cap();
    hn = 16'd1; hm = 16'd2; vn = 16'd1; vm = 16'd1; fn = '0; fm = '0;
    in_valid = 1'b1; in_sof = 1'b1; in_eol = 1'b1; in_data = 16'h1234;
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    check(out_valid === 1'b1 && out_data === 16'h1234, "R2", out_data, 16'h1234);
    check(out_sof === 1'b1 && out_eol === 1'b1, "R7", {out_sof, out_eol}, 3);
    @(posedge clk); #1;
    check(out_valid === 1'b0, "R2", out_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule